// File: doc/BRIEF.md
# ECC Error Capture and Reporting Registers

This block sits beside a memory ECC datapath and keeps a record of the errors it reports. Each cycle the datapath may flag a corrected (single-bit) error, an uncorrectable (multi-bit) error, or both. Each flag comes with the failing byte address and the memory row that was being accessed. The block keeps one sticky flag for each kind of error. It also holds the 4 KB page of the failing address and the row of the first error of each kind. It raises a system-error line for the error kinds that software has enabled.

Software reads and writes three registers over a simple single-cycle bus. Reads are combinational from the selected register. A write takes effect at the next clock edge. Software clears a flag by writing 1 to its bit. While a flag is set, the fields it guards do not change. This keeps the page and row of the first event for software, even when later errors arrive before it services the first.

Top module: `ecc_errlog`

## Requirements
- R1: After reset, every flag, captured page, row field and enable reads as zero, and `sys_err` is low.
- R2: A single-bit event sets the single-bit flag, and a multi-bit event sets the multi-bit flag, at the next clock edge. Each flag is visible at two places: the log register (select 0), with single-bit at bit 0 and multi-bit at bit 1, and the status register (select 1), with single-bit at bit 0 and multi-bit at bit 4. A set flag stays set until software clears it.
- R3: Address bits 31:12 of an event are captured into log register bits 31:12 only if neither flag is set. While either flag is set, the captured page holds its value. Bits 11:2 of the log register read as zero.
- R4: The row of a single-bit event is captured into status bits 3:1, and the row of a multi-bit event into status bits 7:5, only while the matching flag is clear. Each row field then holds until its own flag is cleared. Status bits 31:8 read as zero.
- R5: Writing 1 to a flag bit clears that flag. The single-bit flag is cleared through log bit 0 or status bit 0, and the multi-bit flag through log bit 1 or status bit 4. Writing 0 to a flag bit leaves the flag unchanged. Clearing a flag does not change the captured page or the row fields.
- R6: If an event of a given kind arrives in the same cycle as a clear of its flag, the flag stays set. The guarded fields keep their values, because that flag was already set.
- R7: If a single-bit and a multi-bit event arrive together while both flags are clear, both flags are set. The page is taken from that event's address, and both row fields take that event's row.
- R8: The command register (select 2) holds the single-bit report enable at bit 0 and the multi-bit report enable at bit 1. It is written in full and reads back. Select 3 reads as zero.
- R9: `sys_err` is high in every cycle where (single-bit flag AND its enable) OR (multi-bit flag AND its enable) is true, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sb_evt | input | 1 | Single-bit (corrected) error reported this cycle |
| mb_evt | input | 1 | Multi-bit (uncorrectable) error reported this cycle |
| evt_addr | input | 32 | Byte address of the failing access |
| evt_row | input | 3 | Memory row of the failing access |
| bus_sel | input | 2 | Register select: 0 log, 1 status, 2 command |
| bus_we | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register |
| sys_err | output | 1 | System-error indication |

## Verification
The assertions assume that `evt_addr` and `evt_row` are meaningful only in cycles where an event strobe is high. They also assume that a write strobe, when asserted, applies to one register only in that cycle. Under these assumptions the stickiness and freeze properties can be checked from the registered state alone. The stimulus drives one vector per cycle, then spends an idle cycle with all strobes low and reads the registers back, so every readback reflects exactly one update. Same-cycle collisions (both events together, and an event together with its own clear) are placed as dedicated vectors.

// File: rtl/ecc_errlog_pkg.sv
package ecc_errlog_pkg;

    typedef enum logic [1:0] {
        SEL_LOG  = 2'd0,
        SEL_STAT = 2'd1,
        SEL_CMD  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    localparam int unsigned LOG_SB_BIT = 0;
    localparam int unsigned LOG_MB_BIT = 1;
    localparam int unsigned CMD_SB_BIT = 0;
    localparam int unsigned CMD_MB_BIT = 1;

endpackage

// File: rtl/ecc_errlog_capture.sv
module ecc_errlog_capture #(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned PAGE_SHIFT = 12,
    parameter int unsigned ROW_W      = 3,
    localparam int unsigned PAGE_W    = ADDR_W - PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sb_evt,
    input  logic              mb_evt,
    input  logic [PAGE_W-1:0] evt_page,
    input  logic [ROW_W-1:0]  evt_row,
    input  logic              clr_sb,
    input  logic              clr_mb,
    output logic              sb_flag,
    output logic              mb_flag,
    output logic [PAGE_W-1:0] page,
    output logic [ROW_W-1:0]  sb_row,
    output logic [ROW_W-1:0]  mb_row
);

    typedef struct packed {
        logic              sbe;
        logic              mbe;
        logic [PAGE_W-1:0] page;
        logic [ROW_W-1:0]  sb_row;
        logic [ROW_W-1:0]  mb_row;
    } cap_t;

    cap_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if ((sb_evt || mb_evt) && !st_q.sbe && !st_q.mbe) begin
            st_d.page = evt_page;
        end
        if (sb_evt && !st_q.sbe) begin
            st_d.sb_row = evt_row;
        end
        if (mb_evt && !st_q.mbe) begin
            st_d.mb_row = evt_row;
        end
        st_d.sbe = sb_evt || (st_q.sbe && !clr_sb);
        st_d.mbe = mb_evt || (st_q.mbe && !clr_mb);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sb_flag = st_q.sbe;
    assign mb_flag = st_q.mbe;
    assign page    = st_q.page;
    assign sb_row  = st_q.sb_row;
    assign mb_row  = st_q.mb_row;

    AST_SB_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        sb_evt |=> sb_flag); // R2
    AST_MB_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (mb_flag && !clr_mb) |=> mb_flag); // R2
    AST_PAGE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_flag || mb_flag) |=> $stable(page)); // R3
    AST_SB_ROW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        sb_flag |=> $stable(sb_row)); // R4
    AST_MB_ROW_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        mb_flag |=> $stable(mb_row)); // R4
    AST_EVT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_evt && clr_sb) |=> sb_flag); // R6

endmodule

// File: rtl/ecc_errlog_cmd.sv
module ecc_errlog_cmd (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_we,
    input  logic sb_en_wr,
    input  logic mb_en_wr,
    input  logic sb_flag,
    input  logic mb_flag,
    output logic sb_en,
    output logic mb_en,
    output logic sys_err
);

    typedef struct packed {
        logic sb_en;
        logic mb_en;
    } cmd_t;

    cmd_t cmd_d, cmd_q;

    always_comb begin
        cmd_d = cmd_q;
        if (cmd_we) begin
            cmd_d.sb_en = sb_en_wr;
            cmd_d.mb_en = mb_en_wr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else begin
            cmd_q <= cmd_d;
        end
    end

    assign sb_en   = cmd_q.sb_en;
    assign mb_en   = cmd_q.mb_en;
    assign sys_err = (sb_flag && cmd_q.sb_en) || (mb_flag && cmd_q.mb_en);

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_we |=> ($stable(sb_en) && $stable(mb_en))); // R8
    AST_NO_FLAG_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (!sb_flag && !mb_flag) |-> !sys_err); // R9

endmodule

// File: rtl/ecc_errlog.sv
module ecc_errlog
    import ecc_errlog_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned PAGE_SHIFT = 12,
    parameter int unsigned ROW_W      = 3,
    localparam int unsigned PAGE_W    = ADDR_W - PAGE_SHIFT,
    localparam int unsigned STAT_W    = 2 * ROW_W + 2,
    localparam int unsigned STAT_MB   = ROW_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sb_evt,
    input  logic              mb_evt,
    input  logic [ADDR_W-1:0] evt_addr,
    input  logic [ROW_W-1:0]  evt_row,
    input  logic [1:0]        bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_wdata,
    output logic [ADDR_W-1:0] bus_rdata,
    output logic              sys_err
);

    reg_sel_e          sel;
    logic              clr_sb, clr_mb, cmd_we;
    logic              sb_flag, mb_flag, sb_en, mb_en;
    logic [PAGE_W-1:0] page;
    logic [ROW_W-1:0]  sb_row, mb_row;
    logic [ADDR_W-1:0] log_word, stat_word, cmd_word;
    logic              unused_bits;

    assign sel = reg_sel_e'(bus_sel);

    always_comb begin
        clr_sb = 1'b0;
        clr_mb = 1'b0;
        cmd_we = 1'b0;
        if (bus_we) begin
            case (sel)
                SEL_LOG: begin
                    clr_sb = bus_wdata[LOG_SB_BIT];
                    clr_mb = bus_wdata[LOG_MB_BIT];
                end
                SEL_STAT: begin
                    clr_sb = bus_wdata[0];
                    clr_mb = bus_wdata[STAT_MB];
                end
                SEL_CMD:  cmd_we = 1'b1;
                default:  ;
            endcase
        end
    end

    ecc_errlog_capture #(
        .ADDR_W    (ADDR_W),
        .PAGE_SHIFT(PAGE_SHIFT),
        .ROW_W     (ROW_W)
    ) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .sb_evt  (sb_evt),
        .mb_evt  (mb_evt),
        .evt_page(evt_addr[ADDR_W-1:PAGE_SHIFT]),
        .evt_row (evt_row),
        .clr_sb  (clr_sb),
        .clr_mb  (clr_mb),
        .sb_flag (sb_flag),
        .mb_flag (mb_flag),
        .page    (page),
        .sb_row  (sb_row),
        .mb_row  (mb_row)
    );

    ecc_errlog_cmd u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .cmd_we  (cmd_we),
        .sb_en_wr(bus_wdata[CMD_SB_BIT]),
        .mb_en_wr(bus_wdata[CMD_MB_BIT]),
        .sb_flag (sb_flag),
        .mb_flag (mb_flag),
        .sb_en   (sb_en),
        .mb_en   (mb_en),
        .sys_err (sys_err)
    );

    assign log_word  = {page, {(PAGE_SHIFT-2){1'b0}}, mb_flag, sb_flag};
    assign stat_word = {{(ADDR_W-STAT_W){1'b0}}, mb_row, mb_flag, sb_row, sb_flag};
    assign cmd_word  = {{(ADDR_W-2){1'b0}}, mb_en, sb_en};

    always_comb begin
        case (sel)
            SEL_LOG:  bus_rdata = log_word;
            SEL_STAT: bus_rdata = stat_word;
            SEL_CMD:  bus_rdata = cmd_word;
            default:  bus_rdata = '0;
        endcase
    end

    assign unused_bits = ^{evt_addr[PAGE_SHIFT-1:0], bus_wdata[ADDR_W-1:STAT_MB+1],
                           bus_wdata[STAT_MB-1:2]};

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!sb_flag && !mb_flag && !sys_err)); // R1
    AST_STAT_LOG_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_word[0] == log_word[0]) && (stat_word[STAT_MB] == log_word[1])); // R2
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_sb && !sb_evt) |=> !sb_flag); // R5

endmodule

// File: tb/ecc_errlog_bench.sv
module ecc_errlog_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 13;

    typedef struct packed {
        logic        sb;
        logic        mb;
        logic [31:0] addr;
        logic [2:0]  row;
        logic        we;
        logic [1:0]  sel;
        logic [31:0] wdata;
        logic [31:0] exp_log;
        logic [31:0] exp_stat;
        logic        exp_err;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 32'h0,          3'd0, 1'b1, 2'd2, 32'h3,  32'h0,          32'h0,  1'b0},
        '{1'b1, 1'b0, 32'h1234_5ABC,  3'd2, 1'b0, 2'd0, 32'h0,  32'h1234_5001,  32'h05, 1'b1},
        '{1'b1, 1'b0, 32'hAAAA_A000,  3'd5, 1'b0, 2'd0, 32'h0,  32'h1234_5001,  32'h05, 1'b1},
        '{1'b0, 1'b1, 32'h0F0F_0F0F,  3'd6, 1'b0, 2'd0, 32'h0,  32'h1234_5003,  32'hD5, 1'b1},
        '{1'b0, 1'b0, 32'h0,          3'd0, 1'b1, 2'd0, 32'h1,  32'h1234_5002,  32'hD4, 1'b1},
        '{1'b0, 1'b0, 32'h0,          3'd0, 1'b1, 2'd1, 32'h10, 32'h1234_5000,  32'hC4, 1'b0},
        '{1'b0, 1'b0, 32'h0,          3'd0, 1'b1, 2'd2, 32'h1,  32'h1234_5000,  32'hC4, 1'b0},
        '{1'b0, 1'b1, 32'hFFFF_F123,  3'd7, 1'b0, 2'd0, 32'h0,  32'hFFFF_F002,  32'hF4, 1'b0},
        '{1'b1, 1'b0, 32'h0000_0001,  3'd1, 1'b0, 2'd0, 32'h0,  32'hFFFF_F003,  32'hF3, 1'b1},
        '{1'b0, 1'b0, 32'h0,          3'd0, 1'b1, 2'd0, 32'h0,  32'hFFFF_F003,  32'hF3, 1'b1},
        '{1'b0, 1'b0, 32'h0,          3'd0, 1'b1, 2'd0, 32'h3,  32'hFFFF_F000,  32'hE2, 1'b0},
        '{1'b1, 1'b1, 32'h8000_1000,  3'd3, 1'b0, 2'd0, 32'h0,  32'h8000_1003,  32'h77, 1'b1},
        '{1'b1, 1'b0, 32'h4000_0000,  3'd4, 1'b1, 2'd0, 32'h1,  32'h8000_1003,  32'h77, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sb_evt = 1'b0, mb_evt = 1'b0;
    logic [31:0] evt_addr = '0;
    logic [2:0]  evt_row = '0;
    logic [1:0]  bus_sel = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sys_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_errlog u_ecc_errlog (
        .clk      (clk),
        .rst_n    (rst_n),
        .sb_evt   (sb_evt),
        .mb_evt   (mb_evt),
        .evt_addr (evt_addr),
        .evt_row  (evt_row),
        .bus_sel  (bus_sel),
        .bus_we   (bus_we),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .sys_err  (sys_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] s, output logic [31:0] v);
        bus_sel = s;
        #1;
        v = bus_rdata;
    endtask

    task automatic idle();
        sb_evt = 1'b0; mb_evt = 1'b0; bus_we = 1'b0;
        evt_addr = '0; evt_row = '0; bus_wdata = '0;
    endtask

    initial begin
        logic [31:0] v;
        idle();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        rd(2'd0, v); check("R1 log", v, 32'h0);
        rd(2'd1, v); check("R1 stat", v, 32'h0);
        rd(2'd2, v); check("R1 cmd", v, 32'h0);
        check("R1 sys_err", {31'b0, sys_err}, 32'h0);

        // Vector walk: R2..R9
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            sb_evt = VECS[i].sb; mb_evt = VECS[i].mb;
            evt_addr = VECS[i].addr; evt_row = VECS[i].row;
            bus_we = VECS[i].we; bus_sel = VECS[i].sel; bus_wdata = VECS[i].wdata;
            @(negedge clk);
            idle();
            rd(2'd0, v); check($sformatf("R2 R3 R5 R6 R7 log vec %0d", i), v, VECS[i].exp_log);
            rd(2'd1, v); check($sformatf("R2 R4 R5 R6 R7 stat vec %0d", i), v, VECS[i].exp_stat);
            check($sformatf("R9 sys_err vec %0d", i), {31'b0, sys_err}, {31'b0, VECS[i].exp_err});
            if (i == 6) begin
                rd(2'd2, v); check("R8 cmd readback", v, 32'h1);
            end
        end

        // R8: unused select reads zero
        rd(2'd3, v); check("R8 select 3", v, 32'h0);

        // R9: enable multi-bit reporting with flags set -> high, held over cycles
        @(negedge clk);
        bus_we = 1'b1; bus_sel = 2'd2; bus_wdata = 32'h2;
        @(negedge clk);
        idle();
        check("R9 mb enable", {31'b0, sys_err}, 32'h1);
        @(negedge clk);
        check("R9 held", {31'b0, sys_err}, 32'h1);

        // R1: reset mid-run clears everything
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(2'd0, v); check("R1 log after reset", v, 32'h0);
        rd(2'd1, v); check("R1 stat after reset", v, 32'h0);
        rd(2'd2, v); check("R1 cmd after reset", v, 32'h0);
        check("R1 sys_err after reset", {31'b0, sys_err}, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule